// File: doc/BRIEF.md
# Paged Far Call and Return Sequencer

This block runs the control steps of a far subroutine call, and of the return that matches it, for a CPU with a 64KB local address map. A 16KB window in that map shows one of 256 program pages. An 8-bit page register, reset to `PAGE_RESET`, picks the page. The instruction decoder supplies the operands and a one-cycle start pulse. The block then drives byte-wide stack writes or reads, updates the page register, and ends with a single-cycle program counter load. Once a sequence begins it cannot be interrupted. `busy` stays high from the cycle after the start pulse through the jump cycle. Interrupt logic holds off requests while `busy` is high. Instruction decoding, indirect operand fetch and the stack memory itself are outside this block.

The state machine has nine states: `FC_IDLE`, `FC_SWAP`, `FC_PUSH_LO`, `FC_PUSH_HI`, `FC_PUSH_PG`, `FC_POP_PG`, `FC_POP_HI`, `FC_POP_LO` and `FC_JUMP`.
- The call path is `FC_IDLE -> FC_SWAP -> FC_PUSH_LO -> FC_PUSH_HI -> FC_PUSH_PG -> FC_JUMP -> FC_IDLE`.
- The return path is `FC_IDLE -> FC_POP_PG -> FC_POP_HI -> FC_POP_LO -> FC_JUMP -> FC_IDLE`.
- Every state except `FC_IDLE` moves on unconditionally.
- `FC_IDLE` takes the call path when `call_start` is high. Otherwise it takes the return path when `ret_start` is high.

The stack grows downward. The stack pointer is decremented before each push and incremented after each pop. Stack reads are combinational: `mem_rdata` must be valid in the same cycle as `mem_rd`.

Top module: `farcall_seq`

## Requirements
- R1: After reset, `busy`, `mem_wr`, `mem_rd` and `pc_load` are 0. `page` equals `PAGE_RESET` (0x00) and `sp` equals `SP_RESET` (0x0400).
- R2: A call start taken in idle leaves `page` unchanged during the first busy cycle (`FC_SWAP`). From the second busy cycle on, `page` shows the new page. The old page is kept for the push. While idle with no start, `page` does not change.
- R3: In the second and third busy cycles of a call, `mem_wr` is 1. The first write puts the low byte of the next-instruction address at SP0-1. The second write puts the high byte at SP0-2. SP0 is `sp` when the call starts.
- R4: In the fourth busy cycle of a call, the old page byte is written at SP0-3. `sp` then holds SP0-3.
- R5: The fifth busy cycle of a call asserts `pc_load` for one cycle with `pc_value` equal to the target address. `busy` is 0 in the following cycle.
- R6: A return start taken in idle reads three bytes in consecutive cycles at SP0, SP0+1 and SP0+2. The byte at SP0 goes to `page`, which shows it from the second busy cycle on. The next byte is the high half of the return address and the last byte is the low half. `sp` ends at SP0+3.
- R7: The fourth busy cycle of a return asserts `pc_load` for one cycle with `pc_value` equal to {high byte, low byte}.
- R8: `call_start` and `ret_start`, and any operand values presented with them, are ignored while `busy` is high.
- R9: If `call_start` and `ret_start` are both high in idle, the call sequence runs.
- R10: `mem_wr` and `mem_rd` are never high together. Neither is high while `busy` is 0.
- R11: `busy` stays high without a gap from the cycle after an accepted start through the jump cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_start | input | 1 | One-cycle pulse that starts a far call |
| ret_start | input | 1 | One-cycle pulse that starts a far return |
| new_page | input | PAGE_W | Page to select on call, sampled with `call_start` |
| target_addr | input | ADDR_W | Subroutine address, sampled with `call_start` |
| next_addr | input | ADDR_W | Address of the instruction after the call, sampled with `call_start` |
| mem_rdata | input | PAGE_W | Stack read data, valid in the same cycle as `mem_rd` |
| busy | output | 1 | Sequence in progress; interrupts held off |
| mem_wr | output | 1 | Stack write strobe |
| mem_rd | output | 1 | Stack read strobe |
| mem_addr | output | ADDR_W | Stack byte address |
| mem_wdata | output | PAGE_W | Stack write data |
| page | output | PAGE_W | Program page register |
| sp | output | ADDR_W | Stack pointer |
| pc_load | output | 1 | One-cycle program counter load |
| pc_value | output | ADDR_W | New program counter, valid with `pc_load` |

## Verification
Most faults in this block show up at the ports within one cycle:
- A wrong state shows up in the next cycle as a strobe in the wrong slot, or as a wrong byte or address on the stack bus.
- A corrupted stack pointer appears on `mem_addr` at the next push or pop.

Two faults are slower. A corrupted saved page shows only in the fourth cycle of that call. A stack byte written wrongly stays hidden until its matching return, possibly many calls later. Random nested call and return sequences, with starts injected while busy, are therefore compared cycle by cycle against a bench stack model.

// File: rtl/farcall_pkg.sv
package farcall_pkg;

    typedef enum logic [3:0] {
        FC_IDLE    = 4'd0,
        FC_SWAP    = 4'd1,
        FC_PUSH_LO = 4'd2,
        FC_PUSH_HI = 4'd3,
        FC_PUSH_PG = 4'd4,
        FC_POP_PG  = 4'd5,
        FC_POP_HI  = 4'd6,
        FC_POP_LO  = 4'd7,
        FC_JUMP    = 4'd8
    } fc_state_e;

endpackage

// File: rtl/farcall_fsm.sv
module farcall_fsm
    import farcall_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      call_start,
    input  logic      ret_start,
    output fc_state_e state,
    output logic      busy,
    output logic      take_call
);

    fc_state_e state_q;
    fc_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FC_IDLE: begin
                if (call_start)     state_d = FC_SWAP;
                else if (ret_start) state_d = FC_POP_PG;
            end
            FC_SWAP:    state_d = FC_PUSH_LO;
            FC_PUSH_LO: state_d = FC_PUSH_HI;
            FC_PUSH_HI: state_d = FC_PUSH_PG;
            FC_PUSH_PG: state_d = FC_JUMP;
            FC_POP_PG:  state_d = FC_POP_HI;
            FC_POP_HI:  state_d = FC_POP_LO;
            FC_POP_LO:  state_d = FC_JUMP;
            FC_JUMP:    state_d = FC_IDLE;
            default:    state_d = FC_IDLE;
        endcase
    end

    always_comb begin
        state     = state_q;
        busy      = (state_q != FC_IDLE);
        take_call = (state_q == FC_IDLE) && call_start;
    end

    // R11: an accepted start always leads to a busy cycle
    p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (call_start || ret_start)) |=> busy);

    // R11: the jump state always returns to idle
    p_jump_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FC_JUMP) |=> (state_q == FC_IDLE));

endmodule

// File: rtl/farcall_sp.sv
module farcall_sp #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SP_RESET = 16'h0400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec,
    input  logic              inc,
    output logic [ADDR_W-1:0] sp
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] sp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sp_q <= SP_RESET;
        else if (dec) sp_q <= sp_q - ONE;
        else if (inc) sp_q <= sp_q + ONE;
    end

    assign sp = sp_q;

    // R10: the stack is never pushed and popped in the same cycle
    p_sp_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec && inc));

endmodule

// File: rtl/farcall_page.sv
module farcall_page #(
    parameter int                PAGE_W     = 8,
    parameter logic [PAGE_W-1:0] PAGE_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swap,
    input  logic [PAGE_W-1:0] swap_val,
    input  logic              restore,
    input  logic [PAGE_W-1:0] restore_val,
    output logic [PAGE_W-1:0] page,
    output logic [PAGE_W-1:0] saved
);

    logic [PAGE_W-1:0] page_q;
    logic [PAGE_W-1:0] saved_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q  <= PAGE_RESET;
            saved_q <= PAGE_RESET;
        end else if (swap) begin
            saved_q <= page_q;
            page_q  <= swap_val;
        end else if (restore) begin
            page_q  <= restore_val;
        end
    end

    assign page  = page_q;
    assign saved = saved_q;

    // R2: a swap keeps the outgoing page for the push
    p_swap_keeps_old_r2: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> (saved_q == $past(page_q)));

endmodule

// File: rtl/farcall_seq.sv
module farcall_seq
    import farcall_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                PAGE_W     = 8,
    parameter logic [ADDR_W-1:0] SP_RESET   = 16'h0400,
    parameter logic [PAGE_W-1:0] PAGE_RESET = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_start,
    input  logic              ret_start,
    input  logic [PAGE_W-1:0] new_page,
    input  logic [ADDR_W-1:0] target_addr,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic [PAGE_W-1:0] mem_rdata,
    output logic              busy,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PAGE_W-1:0] mem_wdata,
    output logic [PAGE_W-1:0] page,
    output logic [ADDR_W-1:0] sp,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_value
);

    // The return address is split into two stack bytes of page width.
    localparam int                BYTE_W = ADDR_W / 2;
    localparam logic [ADDR_W-1:0] ONE    = ADDR_W'(1);

    fc_state_e         state;
    logic              take_call;
    logic              sp_dec;
    logic              sp_inc;
    logic              pg_swap;
    logic              pg_restore;
    logic [PAGE_W-1:0] saved_page;

    logic [ADDR_W-1:0] tgt_q;
    logic [ADDR_W-1:0] ret_q;
    logic [PAGE_W-1:0] npg_q;
    logic              is_call_q;

    farcall_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .call_start (call_start),
        .ret_start  (ret_start),
        .state      (state),
        .busy       (busy),
        .take_call  (take_call)
    );

    farcall_sp #(
        .ADDR_W   (ADDR_W),
        .SP_RESET (SP_RESET)
    ) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .dec   (sp_dec),
        .inc   (sp_inc),
        .sp    (sp)
    );

    farcall_page #(
        .PAGE_W     (PAGE_W),
        .PAGE_RESET (PAGE_RESET)
    ) u_page (
        .clk         (clk),
        .rst_n       (rst_n),
        .swap        (pg_swap),
        .swap_val    (npg_q),
        .restore     (pg_restore),
        .restore_val (mem_rdata),
        .page        (page),
        .saved       (saved_page)
    );

    // Operand capture at start, return bytes captured during pops
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q     <= '0;
            ret_q     <= '0;
            npg_q     <= '0;
            is_call_q <= 1'b0;
        end else if (state == FC_IDLE) begin
            if (take_call) begin
                tgt_q     <= target_addr;
                ret_q     <= next_addr;
                npg_q     <= new_page;
                is_call_q <= 1'b1;
            end else if (ret_start) begin
                is_call_q <= 1'b0;
            end
        end else if (state == FC_POP_HI) begin
            ret_q[ADDR_W-1:BYTE_W] <= mem_rdata;
        end else if (state == FC_POP_LO) begin
            ret_q[BYTE_W-1:0] <= mem_rdata;
        end
    end

    // Per-state stack bus, page and jump controls
    always_comb begin
        mem_wr     = 1'b0;
        mem_rd     = 1'b0;
        mem_addr   = sp;
        mem_wdata  = '0;
        sp_dec     = 1'b0;
        sp_inc     = 1'b0;
        pg_swap    = 1'b0;
        pg_restore = 1'b0;
        pc_load    = 1'b0;
        pc_value   = is_call_q ? tgt_q : ret_q;
        unique case (state)
            FC_SWAP: pg_swap = 1'b1;
            FC_PUSH_LO: begin
                mem_wr    = 1'b1;
                mem_addr  = sp - ONE;
                mem_wdata = ret_q[BYTE_W-1:0];
                sp_dec    = 1'b1;
            end
            FC_PUSH_HI: begin
                mem_wr    = 1'b1;
                mem_addr  = sp - ONE;
                mem_wdata = ret_q[ADDR_W-1:BYTE_W];
                sp_dec    = 1'b1;
            end
            FC_PUSH_PG: begin
                mem_wr    = 1'b1;
                mem_addr  = sp - ONE;
                mem_wdata = saved_page;
                sp_dec    = 1'b1;
            end
            FC_POP_PG: begin
                mem_rd     = 1'b1;
                sp_inc     = 1'b1;
                pg_restore = 1'b1;
            end
            FC_POP_HI, FC_POP_LO: begin
                mem_rd = 1'b1;
                sp_inc = 1'b1;
            end
            FC_JUMP: pc_load = 1'b1;
            default: ;
        endcase
    end

    // R10: the stack bus never reads and writes at once
    p_no_rw_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd));

    // R10: the stack bus is quiet while idle
    p_strobe_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr || mem_rd) |-> busy);

    // R3: each push moves the stack pointer down by one
    p_push_sp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (sp == $past(sp) - ONE));

    // R6: each pop moves the stack pointer up by one
    p_pop_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (sp == $past(sp) + ONE));

    // R5: the jump cycle closes the sequence
    p_jump_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !busy);

    // R2: the page register holds while idle without a start
    p_page_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !call_start && !ret_start) |=> $stable(page));

endmodule

// File: tb/farcall_seq_bench.sv
module farcall_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_start = 1'b0;
    logic        ret_start = 1'b0;
    logic [7:0]  new_page = '0;
    logic [15:0] target_addr = '0;
    logic [15:0] next_addr = '0;
    logic [7:0]  mem_rdata;
    logic        busy, mem_wr, mem_rd, pc_load;
    logic [15:0] mem_addr, sp, pc_value;
    logic [7:0]  mem_wdata, page;

    logic [7:0]  bmem [0:255];
    logic [7:0]  mdl_pg  [0:63];
    logic [15:0] mdl_ret [0:63];
    int          depth = 0;
    logic [7:0]  exp_page = 8'h00;
    logic [15:0] exp_sp = 16'h0400;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;
    bit          noise = 0;

    always #10 clk = ~clk;

    farcall_seq u_farcall_seq (
        .clk(clk), .rst_n(rst_n), .call_start(call_start), .ret_start(ret_start),
        .new_page(new_page), .target_addr(target_addr), .next_addr(next_addr),
        .mem_rdata(mem_rdata), .busy(busy), .mem_wr(mem_wr), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .page(page), .sp(sp),
        .pc_load(pc_load), .pc_value(pc_value)
    );

    assign mem_rdata = bmem[mem_addr[7:0]];
    always @(posedge clk) if (mem_wr) bmem[mem_addr[7:0]] <= mem_wdata;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] sp_sub(input logic [15:0] s, input int k);
        return s - 16'(k);
    endfunction

    task automatic inject_noise();
        if (noise) begin
            call_start  = $urandom_range(0, 1);
            ret_start   = $urandom_range(0, 1);
            new_page    = 8'($urandom);
            target_addr = 16'($urandom);
            next_addr   = 16'($urandom);
        end else begin
            call_start = 1'b0;
            ret_start  = 1'b0;
        end
    endtask

    task automatic do_call(input logic [7:0] pg, input logic [15:0] tgt, input logic [15:0] nxt, input bit both);
        logic [15:0] s0 = exp_sp;
        @(negedge clk);
        call_start = 1'b1; ret_start = both; new_page = pg; target_addr = tgt; next_addr = nxt;
        @(negedge clk); inject_noise();
        chk(both ? "R9" : "R11", "busy in swap", busy, 1);
        chk("R2", "page in swap", page, exp_page);
        chk(both ? "R9" : "R10", "no strobe in swap", {mem_wr, mem_rd}, 0);
        @(negedge clk); inject_noise();
        chk("R2", "page after swap", page, pg);
        chk("R3", "lo push", {mem_wr, mem_rd, mem_addr, mem_wdata}, {2'b10, sp_sub(s0, 1), nxt[7:0]});
        @(negedge clk); inject_noise();
        chk("R3", "hi push", {mem_wr, mem_rd, mem_addr, mem_wdata}, {2'b10, sp_sub(s0, 2), nxt[15:8]});
        @(negedge clk); inject_noise();
        chk("R4", "page push", {mem_wr, mem_rd, mem_addr, mem_wdata}, {2'b10, sp_sub(s0, 3), exp_page});
        @(negedge clk); call_start = 1'b0; ret_start = 1'b0;
        chk("R5", "jump", {busy, pc_load, pc_value}, {2'b11, tgt});
        chk("R4", "sp after call", sp, sp_sub(s0, 3));
        @(negedge clk);
        chk(noise ? "R8" : "R5", "idle after call", {busy, pc_load, mem_wr, mem_rd}, 0);
        mdl_pg[depth] = exp_page; mdl_ret[depth] = nxt; depth++;
        exp_page = pg; exp_sp = sp_sub(s0, 3);
    endtask

    task automatic do_ret();
        logic [15:0] s0 = exp_sp;
        logic [7:0]  opg;
        logic [15:0] oret;
        depth--; opg = mdl_pg[depth]; oret = mdl_ret[depth];
        @(negedge clk); ret_start = 1'b1;
        @(negedge clk); inject_noise();
        chk("R6", "pop page", {busy, mem_wr, mem_rd, mem_addr}, {3'b101, s0});
        @(negedge clk); inject_noise();
        chk("R6", "page restored", page, opg);
        chk("R6", "pop hi", {mem_wr, mem_rd, mem_addr}, {2'b01, sp_sub(s0, -1)});
        @(negedge clk); inject_noise();
        chk("R6", "pop lo", {mem_wr, mem_rd, mem_addr}, {2'b01, sp_sub(s0, -2)});
        @(negedge clk); call_start = 1'b0; ret_start = 1'b0;
        chk("R7", "return jump", {busy, pc_load, pc_value}, {2'b11, oret});
        chk("R6", "sp after return", sp, sp_sub(s0, -3));
        @(negedge clk);
        chk(noise ? "R8" : "R11", "idle after return", {busy, pc_load, page}, {2'b00, opg});
        exp_page = opg; exp_sp = sp_sub(s0, -3);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) bmem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1", "reset outputs", {busy, mem_wr, mem_rd, pc_load, page, sp}, {4'b0000, 8'h00, 16'h0400});
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "after release", {busy, page, sp}, {1'b0, 8'h00, 16'h0400});
        // directed corners: extreme pages and addresses, nested, both starts
        do_call(8'hFF, 16'hFFFF, 16'h0000, 0);
        do_call(8'h00, 16'h8000, 16'hABCD, 1);
        noise = 1;
        do_call(8'h5A, 16'h1234, 16'hFF01, 0);
        do_ret();
        noise = 0;
        do_ret();
        do_ret();
        repeat (3) @(negedge clk);
        chk("R2", "page held idle", page, exp_page);
        // random nested traffic
        for (int k = 0; k < 300; k++) begin
            noise = ($urandom_range(0, 3) == 0);
            if (depth > 0 && (depth >= 40 || $urandom_range(0, 1) == 1)) do_ret();
            else do_call(8'($urandom), 16'($urandom), 16'($urandom), $urandom_range(0, 4) == 0 && depth > 0);
        end
        noise = 0;
        while (depth > 0) do_ret();
        chk("R6", "stack unwound", sp, 16'h0400);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R11 watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule